// File: doc/BRIEF.md
# Two-Way Page Descriptor Cache

This block holds recently used page descriptors for an address translation unit. The virtual address space is split into sections, and each section owns eight rows of the cache. Each row has two ways, left and right. A lookup takes a virtual address, picks a row from a few scattered address bits, and compares a 16-bit tag taken from other bits against both ways. The left way is checked first. One cycle later the block reports hit, a rebuilt page descriptor that always reads as present, the 8-bit access field copied from the segment descriptor when the entry was filled, and that segment's cacheable flag.

Fills come from the descriptor walker once it has read a page descriptor from memory. A single "recently written" bit per row chooses the victim, and it lives with the left way. Software maintenance can drop one address, every row of one section, or the whole cache. A walker that has set the referenced or modified flag of a descriptor in memory can OR the same flag into the cached copy.

At most one maintenance request acts in a cycle. Lookups run alongside maintenance and always see the contents as they stood before that cycle's change.

Top module: `pdc_cache`

## Requirements
- R1: The row is {va[31:30], va[17], va[12:11]} (section times eight plus the row within the section) and the tag is {va[29:18], va[16:13]}. va[10:0] has no effect on a lookup, and an address that differs in its section, its row bits or any tag bit misses.
- R2: A lookup presented in cycle t drives hit, pd_out, acc_out and cach_out after the clock edge that ends t. On a hit, pd_out is the stored descriptor ANDed with 0xFFFFF836 with bit 0 forced to 1, acc_out is bits 31:24 of the filling segment descriptor, and cach_out is bit 3 of that segment descriptor. On a miss, or with no lookup, all four outputs are 0.
- R3: A fill whose page descriptor has bit 0 clear changes nothing.
- R4: A fill into a row whose left way is empty writes the left way and clears the row's recently-written bit.
- R5: A fill into a row whose left way is valid and right way is empty writes the right way and sets the recently-written bit.
- R6: A fill into a row with both ways valid writes the right way and sets the bit when the bit is 0, and otherwise writes the left way and clears the bit.
- R7: When both ways of a row hold the looked-up tag, the left way's contents are returned.
- R8: An address flush invalidates only the first matching way, left before right.
- R9: A section flush invalidates both ways of every row in the named section and leaves other sections alone.
- R10: A global flush invalidates every way, and the cache fills normally afterwards.
- R11: A flag update ORs referenced (bit 5) and/or modified (bit 1) into the first valid way whose tag matches. A miss changes nothing.
- R12: Maintenance priority is global flush, section flush, address flush, fill, flag update; a lower request presented with a higher one is dropped. A lookup in the same cycle as a change reports the earlier state.
- R13: Reset empties every way and holds the outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| fill_en | input | 1 | Fill request |
| fill_va | input | 32 | Virtual address being filled |
| fill_sd0 | input | 32 | Segment descriptor word 0 (access byte 31:24, cacheable bit 3) |
| fill_pd | input | 32 | Page descriptor fetched from memory |
| flush_en | input | 1 | Single-address flush request |
| flush_va | input | 32 | Address to flush |
| sflush_en | input | 1 | Section flush request |
| sflush_sec | input | SECT_W (2) | Section to flush |
| gflush_en | input | 1 | Global flush request |
| upd_en | input | 1 | Flag update request |
| upd_va | input | 32 | Address whose cached flags are updated |
| upd_ref | input | 1 | OR the referenced flag (bit 5) |
| upd_mod | input | 1 | OR the modified flag (bit 1) |
| hit | output | 1 | Registered lookup hit |
| pd_out | output | 32 | Rebuilt page descriptor |
| acc_out | output | 8 | Cached access field |
| cach_out | output | 1 | Cached cacheable flag |

## Verification
The bench walks one row through all three victim rules, including the alternation of the recently-written bit once both ways are valid. A design that ignored that bit would evict the same way every time, and the first of two old entries would never leave. Duplicate tags in one row check that the left way is returned first and that an address flush removes only one copy; a design that cleared both copies, or searched right first, returns the wrong descriptor or misses. Other tests cover non-present fills, a flag update that misses, a section flush next to a live section, and requests that collide in one cycle. A wrong priority lets a dropped fill or update leak into the contents, and a lookup that bypasses the state reports the new entry one cycle early.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;
  localparam int TAG_W    = 16;
  localparam int ACC_W    = 8;
  localparam int ROWSEL_W = 3;
  localparam int CACH_BIT = 3;
  localparam int REF_BIT  = 5;
  localparam int MOD_BIT  = 1;
  // Bits of a page descriptor that survive into the cache
  localparam logic [31:0] PD_KEEP = 32'hFFFF_F836;

  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic [TAG_W-1:0] tag;
    logic [31:0]      hi;
  } way_t;

  function automatic logic [TAG_W-1:0] tag_of(input logic [31:0] va);
    return {va[29:18], va[16:13]};
  endfunction

  function automatic logic [ROWSEL_W-1:0] rowsel_of(input logic [31:0] va);
    return {va[17], va[12:11]};
  endfunction
endpackage

// File: rtl/pdc_probe.sv
`timescale 1ns/1ps
module pdc_probe
  import pdc_pkg::*;
(
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] tag_l,
  input  logic [TAG_W-1:0] tag_r,
  input  logic             good_l,
  input  logic             good_r,
  output logic             hit_l,
  output logic             hit_r,
  output logic             hit
);
  // Left way has priority; hit_r only when left does not match
  always_comb begin
    hit_l = good_l && (tag_l == tag);
    hit_r = !hit_l && good_r && (tag_r == tag);
    hit   = hit_l || hit_r;
  end
endmodule

// File: rtl/pdc_victim.sv
`timescale 1ns/1ps
module pdc_victim (
  input  logic good_l,
  input  logic good_r,
  input  logic used,
  output logic pick_right
);
  // Empty left first, then empty right, then the way not written last
  always_comb pick_right = good_l && (!good_r || !used);
endmodule

// File: rtl/pdc_cache.sv
`timescale 1ns/1ps
module pdc_cache
  import pdc_pkg::*;
#(
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [31:0]       lk_va,
  input  logic              fill_en,
  input  logic [31:0]       fill_va,
  input  logic [31:0]       fill_sd0,
  input  logic [31:0]       fill_pd,
  input  logic              flush_en,
  input  logic [31:0]       flush_va,
  input  logic              sflush_en,
  input  logic [SECT_W-1:0] sflush_sec,
  input  logic              gflush_en,
  input  logic              upd_en,
  input  logic [31:0]       upd_va,
  input  logic              upd_ref,
  input  logic              upd_mod,
  output logic              hit,
  output logic [31:0]       pd_out,
  output logic [ACC_W-1:0]  acc_out,
  output logic              cach_out
);
  localparam int ROWS_PER_SECT = 1 << ROWSEL_W;
  localparam int NROWS  = (1 << SECT_W) * ROWS_PER_SECT;
  localparam int ROW_W  = SECT_W + ROWSEL_W;
  localparam int NPROBE = 3;
  localparam int P_LK = 0, P_FL = 1, P_UP = 2;

  way_t             mem_l [NROWS];
  way_t             mem_r [NROWS];
  logic [NROWS-1:0] good_l, good_r, used;

  // ---------------- tag probes: lookup, flush, update ----------------
  logic [31:0]      pr_va  [NPROBE];
  logic [ROW_W-1:0] pr_row [NPROBE];
  logic [NPROBE-1:0] pr_hit_l, pr_hit_r, pr_hit;

  assign pr_va[P_LK] = lk_va;
  assign pr_va[P_FL] = flush_va;
  assign pr_va[P_UP] = upd_va;

  for (genvar p = 0; p < NPROBE; p++) begin : g_probe
    assign pr_row[p] = {pr_va[p][31 -: SECT_W], rowsel_of(pr_va[p])};
    pdc_probe u_probe (
      .tag    (tag_of(pr_va[p])),
      .tag_l  (mem_l[pr_row[p]].tag),
      .tag_r  (mem_r[pr_row[p]].tag),
      .good_l (good_l[pr_row[p]]),
      .good_r (good_r[pr_row[p]]),
      .hit_l  (pr_hit_l[p]),
      .hit_r  (pr_hit_r[p]),
      .hit    (pr_hit[p])
    );
  end

  // ---------------- section mask ----------------
  logic [NROWS-1:0] sec_mask;
  for (genvar r = 0; r < NROWS; r++) begin : g_sec
    localparam logic [SECT_W-1:0] RSEC = SECT_W'(r / ROWS_PER_SECT);
    assign sec_mask[r] = (sflush_sec == RSEC);
  end

  // ---------------- request arbitration ----------------
  logic any_flush, do_g, do_s, do_a, do_f, do_u;
  assign any_flush = gflush_en || sflush_en || flush_en;
  assign do_g = gflush_en;
  assign do_s = sflush_en && !gflush_en;
  assign do_a = flush_en && !sflush_en && !gflush_en;
  assign do_f = fill_en && fill_pd[0] && !any_flush;
  assign do_u = upd_en && !fill_en && !any_flush;

  // ---------------- fill path ----------------
  logic [ROW_W-1:0] f_row;
  way_t             f_word;
  logic             pick_right;
  assign f_row      = {fill_va[31 -: SECT_W], rowsel_of(fill_va)};
  assign f_word.acc = fill_sd0[31:24];
  assign f_word.tag = tag_of(fill_va);
  assign f_word.hi  = (fill_pd & PD_KEEP) | (32'(fill_sd0[CACH_BIT]) << CACH_BIT);

  pdc_victim u_victim (
    .good_l     (good_l[f_row]),
    .good_r     (good_r[f_row]),
    .used       (used[f_row]),
    .pick_right (pick_right)
  );

  logic [31:0] u_mask;
  assign u_mask = (32'(upd_ref) << REF_BIT) | (32'(upd_mod) << MOD_BIT);

  // ---------------- valid and recently-written bits ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      good_l <= '0;
      good_r <= '0;
      used   <= '0;
    end else if (do_g) begin
      good_l <= '0;
      good_r <= '0;
    end else if (do_s) begin
      good_l <= good_l & ~sec_mask;
      good_r <= good_r & ~sec_mask;
    end else if (do_a) begin
      if (pr_hit_l[P_FL])      good_l[pr_row[P_FL]] <= 1'b0;
      else if (pr_hit_r[P_FL]) good_r[pr_row[P_FL]] <= 1'b0;
    end else if (do_f) begin
      // Final U value decided here together with the way write
      if (pick_right) begin
        good_r[f_row] <= 1'b1;
        used[f_row]   <= 1'b1;
      end else begin
        good_l[f_row] <= 1'b1;
        used[f_row]   <= 1'b0;
      end
    end
  end

  // ---------------- way contents (no reset) ----------------
  always_ff @(posedge clk) begin
    if (do_f) begin
      if (pick_right) mem_r[f_row] <= f_word;
      else            mem_l[f_row] <= f_word;
    end else if (do_u) begin
      if (pr_hit_l[P_UP])
        mem_l[pr_row[P_UP]].hi <= mem_l[pr_row[P_UP]].hi | u_mask;
      else if (pr_hit_r[P_UP])
        mem_r[pr_row[P_UP]].hi <= mem_r[pr_row[P_UP]].hi | u_mask;
    end
  end

  // ---------------- registered lookup result ----------------
  way_t lk_sel;
  assign lk_sel = pr_hit_l[P_LK] ? mem_l[pr_row[P_LK]] : mem_r[pr_row[P_LK]];

  always_ff @(posedge clk) begin
    if (rst) begin
      hit      <= 1'b0;
      pd_out   <= '0;
      acc_out  <= '0;
      cach_out <= 1'b0;
    end else if (lk_valid && pr_hit[P_LK]) begin
      hit      <= 1'b1;
      pd_out   <= (lk_sel.hi & PD_KEEP) | 32'h1;
      acc_out  <= lk_sel.acc;
      cach_out <= lk_sel.hi[CACH_BIT];
    end else begin
      hit      <= 1'b0;
      pd_out   <= '0;
      acc_out  <= '0;
      cach_out <= 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{pr_va[P_LK][10:0], pr_va[P_FL][10:0], pr_va[P_UP][10:0],
                         fill_va[10:0], fill_sd0[23:4], fill_sd0[2:0],
                         pr_hit_r[P_LK], pr_hit[P_FL], pr_hit[P_UP], lk_sel.tag};

  // ---------------- assertions ----------------
  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(lk_valid)); // R2
  AST_PD_PRESENT: assert property (@(posedge clk) disable iff (rst)
    hit |-> pd_out[0]); // R2
  AST_ABSENT_FILL_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !fill_pd[0] && !any_flush) |=> ($stable(good_l) && $stable(good_r) && $stable(used))); // R3
  AST_FILL_EMPTY_LEFT: assert property (@(posedge clk) disable iff (rst)
    (do_f && !good_l[f_row]) |=> (good_l[$past(f_row)] && !used[$past(f_row)])); // R4
  AST_FILL_EMPTY_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (do_f && good_l[f_row] && !good_r[f_row]) |=> (good_r[$past(f_row)] && used[$past(f_row)])); // R5
  AST_FILL_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (do_f && good_l[f_row] && good_r[f_row]) |=> (used[$past(f_row)] != $past(used[f_row]))); // R6
  AST_FLUSH_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    (do_a && pr_hit[P_FL]) |=> ($countones({good_l, good_r}) + 1 == $past($countones({good_l, good_r})))); // R8
  AST_SECTION_EMPTY: assert property (@(posedge clk) disable iff (rst)
    do_s |=> (((good_l | good_r) & $past(sec_mask)) == '0)); // R9
  AST_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    gflush_en |=> ((good_l | good_r) == '0)); // R10
endmodule

// File: tb/pdc_cache_tb.sv
`timescale 1ns/1ps
module pdc_cache_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid, fill_en, flush_en, sflush_en, gflush_en, upd_en, upd_ref, upd_mod;
  logic [31:0] lk_va, fill_va, fill_sd0, fill_pd, flush_va, upd_va;
  logic [1:0]  sflush_sec;
  logic        hit, cach_out;
  logic [31:0] pd_out;
  logic [7:0]  acc_out;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pdc_cache u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .fill_en(fill_en), .fill_va(fill_va), .fill_sd0(fill_sd0), .fill_pd(fill_pd),
    .flush_en(flush_en), .flush_va(flush_va), .sflush_en(sflush_en), .sflush_sec(sflush_sec),
    .gflush_en(gflush_en), .upd_en(upd_en), .upd_va(upd_va), .upd_ref(upd_ref), .upd_mod(upd_mod),
    .hit(hit), .pd_out(pd_out), .acc_out(acc_out), .cach_out(cach_out)
  );

  // Address builder per R1: {section, tag[15:4], row[2], tag[3:0], row[1:0], offset}
  function automatic logic [31:0] mkva(input logic [1:0] s, input logic [2:0] r,
                                       input logic [15:0] t, input logic [10:0] o);
    return {s, t[15:4], r[2], t[3:0], r[1:0], o};
  endfunction

  typedef enum logic [2:0] {OP_LOOK, OP_FILL, OP_FLUSH, OP_SFLUSH, OP_GFLUSH, OP_UPD} op_e;
  typedef struct packed {
    op_e         op;
    logic [31:0] va;
    logic [31:0] sd0;
    logic [31:0] pd;   // for OP_UPD: bit 5 = referenced, bit 1 = modified
    logic        eh;
    logic [23:0] rq;
  } vec_t;

  localparam logic [31:0] VA_A  = mkva(2'd0, 3'd3, 16'h0001, 11'h000);
  localparam logic [31:0] VA_AO = mkva(2'd0, 3'd3, 16'h0001, 11'h7ff);
  localparam logic [31:0] VA_X1 = mkva(2'd1, 3'd3, 16'h0001, 11'h000);
  localparam logic [31:0] VA_X2 = mkva(2'd0, 3'd2, 16'h0001, 11'h000);
  localparam logic [31:0] VA_X3 = mkva(2'd0, 3'd3, 16'h8001, 11'h000);
  localparam logic [31:0] VA_B  = mkva(2'd0, 3'd3, 16'h0002, 11'h000);
  localparam logic [31:0] VA_C  = mkva(2'd0, 3'd3, 16'h0003, 11'h123);
  localparam logic [31:0] VA_D  = mkva(2'd0, 3'd3, 16'h0004, 11'h000);
  localparam logic [31:0] VA_E  = mkva(2'd0, 3'd3, 16'h0005, 11'h000);
  localparam logic [31:0] VA_F  = mkva(2'd0, 3'd3, 16'h0006, 11'h000);
  localparam logic [31:0] VA_G  = mkva(2'd0, 3'd3, 16'h0007, 11'h000);
  localparam logic [31:0] VA_H  = mkva(2'd0, 3'd5, 16'h0010, 11'h000);
  localparam logic [31:0] VA_I  = mkva(2'd2, 3'd0, 16'h0abc, 11'h000);
  localparam logic [31:0] VA_J  = mkva(2'd3, 3'd0, 16'h0abc, 11'h000);
  localparam logic [31:0] VA_K  = mkva(2'd1, 3'd1, 16'h0100, 11'h000);
  localparam logic [31:0] VA_L  = mkva(2'd1, 3'd1, 16'h0200, 11'h000);
  localparam logic [31:0] VA_M  = mkva(2'd1, 3'd4, 16'h0300, 11'h000);
  localparam logic [31:0] VA_N  = mkva(2'd1, 3'd5, 16'h0400, 11'h000);
  localparam logic [31:0] VA_P  = mkva(2'd1, 3'd6, 16'h0500, 11'h000);

  localparam logic [31:0] SA = 32'h5A00_0008;
  localparam logic [31:0] SB = 32'hC300_0000;
  localparam logic [31:0] Z  = 32'h0;

  localparam int NV = 55;
  localparam vec_t VT [NV] = '{
    '{OP_LOOK,  VA_A,  Z,  Z,             1'b0, "R13"},
    '{OP_FILL,  VA_A,  SA, 32'hABCD_E8FF, 1'b0, "R4"},
    '{OP_LOOK,  VA_A,  SA, 32'hABCD_E8FF, 1'b1, "R2"},
    '{OP_LOOK,  VA_AO, SA, 32'hABCD_E8FF, 1'b1, "R1"},
    '{OP_LOOK,  VA_X1, Z,  Z,             1'b0, "R1"},
    '{OP_LOOK,  VA_X2, Z,  Z,             1'b0, "R1"},
    '{OP_LOOK,  VA_X3, Z,  Z,             1'b0, "R1"},
    '{OP_FILL,  VA_B,  SB, 32'h0000_1001, 1'b0, "R5"},
    '{OP_LOOK,  VA_B,  SB, 32'h0000_1001, 1'b1, "R5"},
    '{OP_LOOK,  VA_A,  SA, 32'hABCD_E8FF, 1'b1, "R5"},
    '{OP_FILL,  VA_C,  SA, 32'h7777_7835, 1'b0, "R6"},   // U=1 -> left replaced
    '{OP_LOOK,  VA_A,  Z,  Z,             1'b0, "R6"},
    '{OP_LOOK,  VA_B,  SB, 32'h0000_1001, 1'b1, "R6"},
    '{OP_LOOK,  VA_C,  SA, 32'h7777_7835, 1'b1, "R6"},
    '{OP_FILL,  VA_D,  SB, 32'h0F0F_0F01, 1'b0, "R6"},   // U=0 -> right replaced
    '{OP_LOOK,  VA_B,  Z,  Z,             1'b0, "R6"},
    '{OP_LOOK,  VA_D,  SB, 32'h0F0F_0F01, 1'b1, "R6"},
    '{OP_LOOK,  VA_C,  SA, 32'h7777_7835, 1'b1, "R6"},
    '{OP_FILL,  VA_E,  SA, 32'h2222_2000, 1'b0, "R3"},   // not present
    '{OP_LOOK,  VA_E,  Z,  Z,             1'b0, "R3"},
    '{OP_LOOK,  VA_C,  SA, 32'h7777_7835, 1'b1, "R3"},
    '{OP_LOOK,  VA_D,  SB, 32'h0F0F_0F01, 1'b1, "R3"},
    '{OP_UPD,   VA_C,  Z,  32'h0000_0022, 1'b0, "R11"},
    '{OP_LOOK,  VA_C,  SA, 32'h7777_7837, 1'b1, "R11"},
    '{OP_UPD,   VA_A,  Z,  32'h0000_0022, 1'b0, "R11"},  // miss
    '{OP_LOOK,  VA_D,  SB, 32'h0F0F_0F01, 1'b1, "R11"},
    '{OP_UPD,   VA_D,  Z,  32'h0000_0020, 1'b0, "R11"},  // right way, ref only
    '{OP_LOOK,  VA_D,  SB, 32'h0F0F_0F21, 1'b1, "R11"},
    '{OP_FLUSH, VA_C,  Z,  Z,             1'b0, "R8"},
    '{OP_LOOK,  VA_C,  Z,  Z,             1'b0, "R8"},
    '{OP_LOOK,  VA_D,  SB, 32'h0F0F_0F21, 1'b1, "R8"},
    '{OP_FILL,  VA_F,  SA, 32'h3333_3021, 1'b0, "R4"},   // left empty again
    '{OP_FILL,  VA_G,  SB, 32'h4444_4803, 1'b0, "R6"},   // U cleared -> right
    '{OP_LOOK,  VA_D,  Z,  Z,             1'b0, "R6"},
    '{OP_LOOK,  VA_F,  SA, 32'h3333_3021, 1'b1, "R4"},
    '{OP_LOOK,  VA_G,  SB, 32'h4444_4803, 1'b1, "R6"},
    '{OP_FILL,  VA_H,  SA, 32'h1111_1001, 1'b0, "R7"},
    '{OP_FILL,  VA_H,  SB, 32'h2222_2003, 1'b0, "R7"},
    '{OP_LOOK,  VA_H,  SA, 32'h1111_1001, 1'b1, "R7"},
    '{OP_FLUSH, VA_H,  Z,  Z,             1'b0, "R8"},
    '{OP_LOOK,  VA_H,  SB, 32'h2222_2003, 1'b1, "R8"},
    '{OP_FLUSH, VA_H,  Z,  Z,             1'b0, "R8"},
    '{OP_LOOK,  VA_H,  Z,  Z,             1'b0, "R8"},
    '{OP_FILL,  VA_I,  SA, 32'h5555_5011, 1'b0, "R9"},
    '{OP_FILL,  VA_J,  SB, 32'h6666_6005, 1'b0, "R9"},
    '{OP_SFLUSH,VA_I,  Z,  Z,             1'b0, "R9"},
    '{OP_LOOK,  VA_I,  Z,  Z,             1'b0, "R9"},
    '{OP_LOOK,  VA_J,  SB, 32'h6666_6005, 1'b1, "R9"},
    '{OP_LOOK,  VA_F,  SA, 32'h3333_3021, 1'b1, "R9"},
    '{OP_GFLUSH,Z,     Z,  Z,             1'b0, "R10"},
    '{OP_LOOK,  VA_F,  Z,  Z,             1'b0, "R10"},
    '{OP_LOOK,  VA_J,  Z,  Z,             1'b0, "R10"},
    '{OP_LOOK,  VA_G,  Z,  Z,             1'b0, "R10"},
    '{OP_FILL,  VA_F,  SB, 32'h0000_1001, 1'b0, "R10"},
    '{OP_LOOK,  VA_F,  SB, 32'h0000_1001, 1'b1, "R10"}
  };

  task automatic clear_in();
    lk_valid = 0; lk_va = '0; fill_en = 0; fill_va = '0; fill_sd0 = '0; fill_pd = '0;
    flush_en = 0; flush_va = '0; sflush_en = 0; sflush_sec = '0; gflush_en = 0;
    upd_en = 0; upd_va = '0; upd_ref = 0; upd_mod = 0;
  endtask

  task automatic expect_out(input logic eh, input logic [31:0] sd0, input logic [31:0] pd,
                            input logic [23:0] rq);
    logic [31:0] ep;
    logic [7:0]  ea;
    logic        ec;
    ep = eh ? ((pd & 32'hFFFF_F836) | 32'h1) : 32'h0;
    ea = eh ? sd0[31:24] : 8'h0;
    ec = eh ? sd0[3] : 1'b0;
    checks++;
    if (hit !== eh || pd_out !== ep || acc_out !== ea || cach_out !== ec) begin
      fails++;
      $display("FAIL %s: hit=%0b pd=%h acc=%h cach=%0b expected hit=%0b pd=%h acc=%h cach=%0b",
               rq, hit, pd_out, acc_out, cach_out, eh, ep, ea, ec);
    end
  endtask

  task automatic apply(input vec_t v);
    case (v.op)
      OP_LOOK:   begin lk_valid = 1; lk_va = v.va; end
      OP_FILL:   begin fill_en = 1; fill_va = v.va; fill_sd0 = v.sd0; fill_pd = v.pd; end
      OP_FLUSH:  begin flush_en = 1; flush_va = v.va; end
      OP_SFLUSH: begin sflush_en = 1; sflush_sec = v.va[31:30]; end
      OP_GFLUSH: gflush_en = 1;
      default:   begin upd_en = 1; upd_va = v.va; upd_ref = v.pd[5]; upd_mod = v.pd[1]; end
    endcase
    @(negedge clk);
    if (v.op == OP_LOOK) expect_out(v.eh, v.sd0, v.pd, v.rq);
    clear_in();
  endtask

  task automatic look(input logic [31:0] va, input logic eh, input logic [31:0] sd0,
                      input logic [31:0] pd, input logic [23:0] rq);
    lk_valid = 1; lk_va = va;
    @(negedge clk);
    expect_out(eh, sd0, pd, rq);
    clear_in();
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] sd0, input logic [31:0] pd);
    fill_en = 1; fill_va = va; fill_sd0 = sd0; fill_pd = pd;
    @(negedge clk);
    clear_in();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual=still running expected=finished");
    summary();
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    expect_out(1'b0, Z, Z, "R13");   // outputs held at 0 in reset
    rst = 0;

    for (int i = 0; i < NV; i++) apply(VT[i]);

    // R12: global flush wins over a fill in the same cycle
    fill_en = 1; fill_va = VA_K; fill_sd0 = SA; fill_pd = 32'hABCD_E8FF; gflush_en = 1;
    @(negedge clk); clear_in();
    look(VA_K, 1'b0, Z, Z, "R12");

    // R12: address flush wins over a fill into the same row
    fill(VA_K, SA, 32'hABCD_E8FF);
    look(VA_K, 1'b1, SA, 32'hABCD_E8FF, "R12");
    flush_en = 1; flush_va = VA_K;
    fill_en = 1; fill_va = VA_L; fill_sd0 = SB; fill_pd = 32'h0000_1001;
    @(negedge clk); clear_in();
    look(VA_K, 1'b0, Z, Z, "R12");
    look(VA_L, 1'b0, Z, Z, "R12");

    // R12: lookup beside a fill sees the earlier contents
    fill_en = 1; fill_va = VA_M; fill_sd0 = SB; fill_pd = 32'h0000_1001;
    lk_valid = 1; lk_va = VA_M;
    @(negedge clk);
    expect_out(1'b0, Z, Z, "R12");
    clear_in();
    look(VA_M, 1'b1, SB, 32'h0000_1001, "R12");

    // R12: flag update dropped when a fill is presented with it
    fill_en = 1; fill_va = VA_N; fill_sd0 = SA; fill_pd = 32'h0000_3001;
    upd_en = 1; upd_va = VA_M; upd_ref = 1; upd_mod = 1;
    @(negedge clk); clear_in();
    look(VA_M, 1'b1, SB, 32'h0000_1001, "R12");
    look(VA_N, 1'b1, SA, 32'h0000_3001, "R12");

    // R13: reset in mid-run empties the cache and zeroes outputs
    fill(VA_P, SA, 32'h0000_5001);
    look(VA_P, 1'b1, SA, 32'h0000_5001, "R13");
    rst = 1; lk_valid = 1; lk_va = VA_P;
    @(negedge clk);
    expect_out(1'b0, Z, Z, "R13");
    @(negedge clk);
    rst = 0; clear_in();
    look(VA_P, 1'b0, Z, Z, "R13");

    summary();
    $finish;
  end
endmodule